// File: doc/BRIEF.md
# Standby Clock Enable Controller

This block decides when the processor core stops its clock to save power and when it starts again. The pipeline sends a one-cycle pulse when a halt-until-interrupt instruction leaves its last stage. If the system bus is idle in that same cycle, the block drops the core clock enable and the pipeline freezes. If the bus is busy in that cycle, the block does not enter standby. It instead pulses a flag that tells the pipeline to retire the instruction as a no-op. Either way, the instruction turns on interrupt acceptance.

An always-on section keeps running whatever the state of the core. It holds a free-running interval timer and the input registers that sample the external interrupt lines. The timer's count and tick are brought out ungated, so the always-on activity can be seen from outside. Any sampled interrupt wakes the core, and so does a timer tick. The clock enable comes back on the cycle after the interrupt is sampled. A synchronous warm reset, or the asynchronous cold reset, clears every state element. The clock gate itself is modelled as an enable signal.

Top module: `standby_ctrl`

## Requirements
- R1: After cold reset, core_clk_en_o=1, standby_o=0, wait_nop_o=0, int_en_o=0, timer_cnt_o=0 and timer_irq_o=0.
- R2: When the core is running and wait_done_i=1 with bus_idle_i=1 at a clock edge, standby_o rises and core_clk_en_o falls after that edge. Standby is never entered without that condition.
- R3: When the core is running and wait_done_i=1 with bus_idle_i=0 at an edge, standby is not entered and wait_nop_o is 1 for exactly the following cycle. wait_nop_o is 1 at no other time.
- R4: Every wait_done_i accepted while running sets int_en_o to 1. It stays set until a reset.
- R5: Any bit of irq_i that is 1 at edge k is sampled there. If the core is in standby, core_clk_en_o returns to 1 after edge k+1.
- R6: timer_cnt_o counts 0..TIMER_PERIOD-1 and wraps, in standby and while running. timer_irq_o is 1 for the one cycle after the count reaches TIMER_PERIOD-1. A timer tick wakes the core from standby at the next edge.
- R7: While in standby, wait_done_i has no effect: no no-op pulse, no change of state.
- R8: warm_rst_i=1 at an edge returns every output to its R1 value after that edge.
- R9: Interrupts sampled while the core is running leave standby_o, int_en_o and wait_nop_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset |
| wait_done_i | input | 1 | Halt instruction finished its last pipeline stage |
| bus_idle_i | input | 1 | System bus has no transaction in progress |
| irq_i | input | IRQ_W | External interrupt request lines |
| core_clk_en_o | output | 1 | Enable for the gated core clock |
| standby_o | output | 1 | Core is in standby |
| wait_nop_o | output | 1 | Pulse: retire the halt instruction as a no-op |
| int_en_o | output | 1 | Interrupt acceptance enabled |
| timer_cnt_o | output | CNT_W | Ungated always-on timer count |
| timer_irq_o | output | 1 | Timer tick, one cycle per period |

## Verification
Halt completions are applied with the bus idle and with the bus busy. This separates true standby entry from the no-op path. Completions are also applied while already in standby, to show that they are ignored. Wakeups are driven separately by external lines and by the timer alone, so that each wake source is tried by itself. Interrupts raised while the core runs show that sampling does not disturb the state. Random mixes of all inputs, including warm resets, are compared every cycle against a reference model in the bench.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/aon_timer.sv
module aon_timer #(
  parameter int unsigned PERIOD = 1024,
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          tick_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= at_last ? '0 : cnt_q + 1'b1;
      tick_q <= at_last;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

  p_timer_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) && !clr_i |=> (cnt_q == '0) && tick_q);
  p_tick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q && !clr_i |=> !tick_q || (PERIOD == 1));
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned IRQ_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic             timer_tick_i,
  output logic             wake_o
);
  logic [IRQ_W-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= '0;
    else if (clr_i) irq_q <= '0;
    else            irq_q <= irq_i;
  end

  assign wake_o = (|irq_q) | timer_tick_i;

  p_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) && !clr_i |=> wake_o);
endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wait_done_i,
  input  logic bus_idle_i,
  input  logic wake_i,
  output logic standby_o,
  output logic wait_nop_o,
  output logic int_en_o
);
  pwr_state_e state_q, state_d;
  logic       nop_q, nop_d;
  logic       ie_q, ie_d;
  logic       running;

  assign running = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    nop_d   = 1'b0;
    ie_d    = ie_q;
    unique case (state_q)
      ST_RUN: begin
        if (wait_done_i) begin
          ie_d = 1'b1;
          if (bus_idle_i) state_d = ST_SLEEP;
          else            nop_d   = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      nop_q   <= 1'b0;
      ie_q    <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_RUN;
      nop_q   <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      nop_q   <= nop_d;
      ie_q    <= ie_d;
    end
  end

  assign standby_o  = (state_q == ST_SLEEP);
  assign wait_nop_o = nop_q;
  assign int_en_o   = ie_q;

  p_entry_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> $past(wait_done_i && bus_idle_i && !clr_i));
  p_nop_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_nop_o |-> !standby_o && $past(wait_done_i && !bus_idle_i && running));
  p_ie_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && wait_done_i && !clr_i |=> int_en_o);
  p_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o && wake_i |=> !standby_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o && !wake_i && !clr_i |=> standby_o && !wait_nop_o);
  p_warm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !standby_o && !int_en_o && !wait_nop_o);
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
  parameter int unsigned IRQ_W        = 6,
  parameter int unsigned TIMER_PERIOD = 1024,
  localparam int unsigned CNT_W = (TIMER_PERIOD > 1) ? $clog2(TIMER_PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             wait_done_i,
  input  logic             bus_idle_i,
  input  logic [IRQ_W-1:0] irq_i,
  output logic             core_clk_en_o,
  output logic             standby_o,
  output logic             wait_nop_o,
  output logic             int_en_o,
  output logic [CNT_W-1:0] timer_cnt_o,
  output logic             timer_irq_o
);
  logic tick;
  logic wake;
  logic sb;

  aon_timer #(.PERIOD(TIMER_PERIOD)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (warm_rst_i),
    .cnt_o  (timer_cnt_o),
    .tick_o (tick)
  );

  irq_sampler #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (warm_rst_i),
    .irq_i        (irq_i),
    .timer_tick_i (tick),
    .wake_o       (wake)
  );

  standby_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (warm_rst_i),
    .wait_done_i (wait_done_i),
    .bus_idle_i  (bus_idle_i),
    .wake_i      (wake),
    .standby_o   (sb),
    .wait_nop_o  (wait_nop_o),
    .int_en_o    (int_en_o)
  );

  assign standby_o     = sb;
  assign core_clk_en_o = !sb;
  assign timer_irq_o   = tick;

  // always-on timer must advance while the core is frozen
  p_timer_runs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb && !warm_rst_i && !timer_irq_o |=> timer_cnt_o != $past(timer_cnt_o));
  p_timer_wakes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb && timer_irq_o |=> core_clk_en_o);
endmodule

// File: tb/tb_standby_ctrl.sv
`timescale 1ns/1ps
module tb_standby_ctrl;
  localparam int unsigned IRQ_W = 6;
  localparam int unsigned PER   = 16;
  localparam int unsigned CW    = $clog2(PER);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warm = 1'b0, wd = 1'b0, idle = 1'b0;
  logic [IRQ_W-1:0] irq = '0;
  logic en, sb, nop, ie, tirq;
  logic [CW-1:0] cnt;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference model state
  logic [CW-1:0] m_cnt;
  logic m_tick, m_irq, m_sb, m_nop, m_ie;

  always #2.5 clk = ~clk;

  standby_ctrl #(.IRQ_W(IRQ_W), .TIMER_PERIOD(PER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .wait_done_i(wd),
    .bus_idle_i(idle), .irq_i(irq), .core_clk_en_o(en), .standby_o(sb),
    .wait_nop_o(nop), .int_en_o(ie), .timer_cnt_o(cnt), .timer_irq_o(tirq)
  );

  function automatic logic next_sb(logic s, logic w, logic i, logic wake);
    return s ? !wake : (w && i);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || warm) begin
      m_cnt = '0; m_tick = 0; m_irq = 0; m_sb = 0; m_nop = 0; m_ie = 0;
    end else begin
      logic wake;
      wake   = m_irq | m_tick;
      m_nop  = !m_sb && wd && !idle;
      m_ie   = m_ie | (!m_sb && wd);
      m_sb   = next_sb(m_sb, wd, idle, wake);
      m_tick = (m_cnt == CW'(PER - 1));
      m_cnt  = m_tick ? '0 : m_cnt + 1'b1;
      m_irq  = |irq;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R2 clk_en", 32'(en), 32'(!m_sb));
    chk("R2 standby", 32'(sb), 32'(m_sb));
    chk("R3 nop", 32'(nop), 32'(m_nop));
    chk("R4 int_en", 32'(ie), 32'(m_ie));
    chk("R6 cnt", 32'(cnt), 32'(m_cnt));
    chk("R6 tick", 32'(tirq), 32'(m_tick));
  endtask

  task automatic cyc(logic w, logic i, logic [IRQ_W-1:0] q, logic r);
    wd = w; idle = i; irq = q; warm = r;
    @(negedge clk);
    cmp_model();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en", 32'(en), 1); chk("R1 sb", 32'(sb), 0);
    chk("R1 nop", 32'(nop), 0); chk("R1 ie", 32'(ie), 0);
    chk("R1 cnt", 32'(cnt), 0); chk("R1 tick", 32'(tirq), 0);
    rst_n = 1'b1;
    cyc(0, 1, '0, 0);
    // R3 busy completion -> no-op pulse
    cyc(1, 0, '0, 0);
    chk("R3 nop pulse", 32'(nop), 1); chk("R3 no sb", 32'(sb), 0);
    chk("R4 ie", 32'(ie), 1);
    cyc(0, 0, '0, 0);
    chk("R3 nop ends", 32'(nop), 0);
    // R9 irq while running
    cyc(0, 1, 6'h21, 0); cyc(0, 1, '0, 0); cyc(0, 1, '0, 0);
    chk("R9 sb", 32'(sb), 0); chk("R9 nop", 32'(nop), 0); chk("R9 ie", 32'(ie), 1);
    // R8 warm reset
    cyc(0, 1, '0, 1);
    chk("R8 ie", 32'(ie), 0); chk("R8 cnt", 32'(cnt), 0);
    cyc(0, 1, '0, 0);
    // R2 entry, R7 ignored wait, R5 external wake
    cyc(1, 1, '0, 0);
    chk("R2 sb", 32'(sb), 1); chk("R2 en", 32'(en), 0);
    cyc(1, 0, '0, 0);
    chk("R7 no nop", 32'(nop), 0);
    cyc(0, 1, 6'h04, 0); cyc(0, 1, '0, 0);
    chk("R5 wake", 32'(en), 1);
    // R6 timer wake with no external irq
    cyc(1, 1, '0, 0);
    for (int k = 0; k < 40 && !(tirq && sb); k++) begin
      if (!sb) cyc(1, 1, '0, 0);
      else     cyc(0, 1, '0, 0);
    end
    chk("R6 tick in sb", 32'(tirq && sb), 1);
    cyc(0, 1, '0, 0);
    chk("R6 timer wake", 32'(en), 1);
    // random mix
    void'($urandom(32'h5eed));
    for (int k = 0; k < 4000; k++) begin
      logic [IRQ_W-1:0] q;
      q = (($urandom % 12) == 0) ? IRQ_W'($urandom) : '0;
      cyc(($urandom % 4) == 0, $urandom % 2, q, ($urandom % 300) == 0);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule